// File: doc/BRIEF.md
# Packetized one-time-programmable memory read controller

This block reads a one-time-programmable array whose contents are a chain of variable-length packets. Each packet is one header word followed by its payload. Software places a word address in the upper half of a mode register and then sets the start bit in the control register. The block walks the chain of headers from word 0 until it reaches the packet whose span holds that address. It then copies that whole packet into a local buffer.

While the copy runs, a status bit reads high. When the status bit clears, the header is visible in a header register. The payload is fetched by writing a start index and then reading a data register over and over. Every read of the data register moves the index forward by one.

The array is modelled as a synchronous ROM whose content is computed, with a configurable access latency. The bus is a plain single-cycle register port. A read returns its value on `bus_rdata` one cycle after the strobe.

Top module: `otpr_pkt_reader`

## Requirements
- R1: A write to offset 0x00 with bit 6 set, while idle, starts a transfer. From the next cycle until the transfer ends, a read of offset 0x0C returns bit 6 = 1.
- R2: When a transfer ends, status bit 6 returns to 0. The header register at offset 0x20 then holds the header of the packet that was found, and the payload size N sits in bits 15:8 of that header.
- R3: The requested word address is bits 31:16 of the mode register at offset 0x04. Any address in [start_k, start_k + N_k + 2) loads packet k, where start_k is the address of packet k's header word.
- R4: After 0 is written to the index register at offset 0x08, successive reads of offset 0x24 return payload words 0 to N of the loaded packet in order, which is N+1 words. Each of these reads advances the index by one.
- R5: Reads of offset 0x24 at or beyond the packet's N+1 words return 0. The index stops at PBUF.
- R6: A start write made while status bit 6 is high is ignored, and the transfer that is running completes with its own packet.
- R7: The start bit is self-clearing, so offset 0x00 always reads as 0.
- R8: If the walk meets a header whose size field is 0 before it reaches the address, or if it runs past the end of the array, the header register reads 0, busy clears, and offset 0x24 reads 0.
- R9: The mode register reads back the full 32-bit value written to it. The index register reads back the current index.
- R10: After reset, status, header, mode and index all read 0.
- R11: Writing the value j to the index register starts the data stream at payload word j.
- R12: The model array holds NPKT packets laid end to end from word 0, followed by zeros. Packet k has size N_k = (3k mod 7) + 1. Its header is {8'h5A, k[7:0], N_k, 8'h3C}. Its payload word j is {k[7:0], j[7:0], ~k[7:0], ~j[7:0]}.
- R13: A read strobe at offset A places the register value on `bus_rdata` in the following cycle. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |

## Verification
The assertions assume that the register port carries at most one access per cycle, so a read and a write never share a cycle. They also assume that software does not read the payload data register while a transfer is running. A further assumption is that every packet in the model fits the local buffer, which R12's sizes guarantee for the default PBUF. The bench drives the port only through tasks that issue one strobe at a time. It polls the status register before it touches the header or payload, and its one deliberate start during busy targets a packet different from the running one, so that a design which failed to ignore it would load the wrong header.

// File: rtl/otpr_pkg.sv
package otpr_pkg;

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_MODE = 8'h04;
  localparam logic [7:0] OFF_IDX  = 8'h08;
  localparam logic [7:0] OFF_STAT = 8'h0C;
  localparam logic [7:0] OFF_HDR  = 8'h20;
  localparam logic [7:0] OFF_DATA = 8'h24;

  localparam int unsigned START_BIT   = 6;
  localparam int unsigned BUSY_BIT    = 6;
  localparam int unsigned IMG_MAX_PKT = 16;

  typedef enum logic [1:0] {
    F_IDLE,
    F_HISSUE,
    F_HWAIT,
    F_PLOAD
  } fetch_state_e;

  // Size field of packet k in the modelled image.
  function automatic logic [7:0] img_size(int unsigned k);
    return 8'(((k * 3) % 7) + 1);
  endfunction

  function automatic logic [31:0] img_header(int unsigned k);
    logic [7:0] kb;
    kb = 8'(k);
    return {8'h5A, kb, img_size(k), 8'h3C};
  endfunction

  function automatic logic [31:0] img_payload(int unsigned k, int unsigned j);
    logic [7:0] kb;
    logic [7:0] jb;
    kb = 8'(k);
    jb = 8'(j);
    return {kb, jb, ~kb, ~jb};
  endfunction

  // Words a packet of the given size occupies: header plus size+1 payload.
  function automatic int unsigned pkt_span(logic [7:0] sz);
    return 32'(sz) + 2;
  endfunction

  // Content of word a of the modelled array holding npkt packets.
  function automatic logic [31:0] img_word(int unsigned a, int unsigned npkt);
    int unsigned base;
    int unsigned span;
    logic [31:0] w;
    base = 0;
    w    = '0;
    for (int unsigned k = 0; k < IMG_MAX_PKT; k++) begin
      if (k < npkt) begin
        span = pkt_span(img_size(k));
        if (a == base)
          w = img_header(k);
        else if (a > base && a < base + span)
          w = img_payload(k, a - base - 1);
        base = base + span;
      end
    end
    return w;
  endfunction

endpackage

// File: rtl/otpr_rom.sv
module otpr_rom #(
  parameter int unsigned AW   = 12,
  parameter int unsigned LAT  = 2,
  parameter int unsigned NPKT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  output logic          vld_o,
  output logic [31:0]   data_o
);
  import otpr_pkg::*;

  logic [LAT-1:0] v_pipe;
  logic [31:0]    d_pipe [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_pipe[0] <= 1'b0;
    else        v_pipe[0] <= req_i;
  end

  always_ff @(posedge clk) begin
    d_pipe[0] <= img_word(32'(addr_i), NPKT);
  end

  for (genvar g = 1; g < LAT; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_pipe[g] <= 1'b0;
      else        v_pipe[g] <= v_pipe[g-1];
    end
    always_ff @(posedge clk) begin
      d_pipe[g] <= d_pipe[g-1];
    end
  end

  assign vld_o  = v_pipe[LAT-1];
  assign data_o = d_pipe[LAT-1];

endmodule

// File: rtl/otpr_fetch.sv
module otpr_fetch #(
  parameter int unsigned AW        = 12,
  parameter int unsigned PBUF      = 8,
  parameter int unsigned OTP_WORDS = 2816,
  parameter int unsigned CW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [15:0]   target_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [31:0]   hdr_o,
  output logic [CW-1:0] nwords_o,
  input  logic [CW-1:0] rd_idx_i,
  output logic [31:0]   rd_word_o,
  output logic          rom_req_o,
  output logic [AW-1:0] rom_addr_o,
  input  logic          rom_vld_i,
  input  logic [31:0]   rom_data_i
);
  import otpr_pkg::*;

  localparam int unsigned BW = (PBUF > 1) ? $clog2(PBUF) : 1;

  fetch_state_e  state_q;
  logic [15:0]   target_q;
  logic [AW-1:0] walk_q;
  logic [31:0]   hdr_q;
  logic [CW-1:0] nwords_q;
  logic [CW-1:0] issue_q;
  logic [CW-1:0] recv_q;
  logic [31:0]   pbuf [PBUF];

  // Named events for the assertions.
  logic          fetch_start;
  logic          hdr_seen;
  logic          hdr_zero;
  logic          hdr_hit;
  logic          hdr_skip;
  logic          walk_end;
  logic          last_recv;
  logic          pay_vld;
  logic [7:0]    hdr_size;
  logic [31:0]   next_base;
  logic [CW-1:0] nwords_n;

  assign fetch_start = start_i && (state_q == F_IDLE);
  assign hdr_seen    = (state_q == F_HWAIT) && rom_vld_i;
  assign hdr_size    = rom_data_i[15:8];
  assign next_base   = 32'(walk_q) + pkt_span(hdr_size);
  assign hdr_zero    = hdr_seen && (hdr_size == 8'd0);
  assign hdr_hit     = hdr_seen && !hdr_zero && (32'(target_q) < next_base);
  assign hdr_skip    = hdr_seen && !hdr_zero && !hdr_hit;
  assign walk_end    = hdr_skip && (next_base >= OTP_WORDS);
  assign pay_vld     = (state_q == F_PLOAD) && rom_vld_i;
  assign last_recv   = pay_vld && (recv_q == nwords_q - CW'(1));
  assign done_o      = hdr_zero || walk_end || last_recv;
  assign busy_o      = (state_q != F_IDLE);

  assign nwords_n = (32'(hdr_size) + 1 > PBUF) ? CW'(PBUF) : CW'(32'(hdr_size) + 1);

  always_comb begin
    rom_req_o  = 1'b0;
    rom_addr_o = walk_q;
    if (state_q == F_HISSUE) begin
      rom_req_o = 1'b1;
    end else if (state_q == F_PLOAD && issue_q < nwords_q) begin
      rom_req_o  = 1'b1;
      rom_addr_o = AW'(32'(walk_q) + 32'(issue_q) + 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= F_IDLE;
      target_q <= '0;
      walk_q   <= '0;
      hdr_q    <= '0;
      nwords_q <= '0;
      issue_q  <= '0;
      recv_q   <= '0;
    end else begin
      case (state_q)
        F_IDLE: if (fetch_start) begin
          target_q <= target_i;
          walk_q   <= '0;
          nwords_q <= '0;
          state_q  <= F_HISSUE;
        end
        F_HISSUE: state_q <= F_HWAIT;
        F_HWAIT: begin
          if (hdr_zero || walk_end) begin
            hdr_q    <= '0;
            nwords_q <= '0;
            state_q  <= F_IDLE;
          end else if (hdr_hit) begin
            hdr_q    <= rom_data_i;
            nwords_q <= nwords_n;
            issue_q  <= '0;
            recv_q   <= '0;
            state_q  <= F_PLOAD;
          end else if (hdr_skip) begin
            walk_q  <= AW'(next_base);
            state_q <= F_HISSUE;
          end
        end
        F_PLOAD: begin
          if (rom_req_o) issue_q <= issue_q + CW'(1);
          if (pay_vld)   recv_q  <= recv_q + CW'(1);
          if (last_recv) state_q <= F_IDLE;
        end
        default: state_q <= F_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (pay_vld) pbuf[recv_q[BW-1:0]] <= rom_data_i;
  end

  assign hdr_o     = hdr_q;
  assign nwords_o  = nwords_q;
  assign rd_word_o = (rd_idx_i < nwords_q) ? pbuf[rd_idx_i[BW-1:0]] : 32'd0;

  // R1: an accepted start makes the block busy in the next cycle.
  p_busy_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |=> busy_o);

  // R2: completion always returns the block to idle.
  p_idle_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  // R3: a selected packet never starts above the requested address.
  p_hit_covers_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_hit |-> (32'(target_q) >= 32'(walk_q)));

  // R4: payload words are never received before they are requested.
  p_recv_le_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == F_PLOAD) |-> (recv_q <= issue_q));

  // R6: the latched address is held for the whole transfer.
  p_target_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> $stable(target_q));

endmodule

// File: rtl/otpr_regs.sv
module otpr_regs #(
  parameter int unsigned PBUF = 8,
  parameter int unsigned CW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [7:0]    addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          busy_i,
  input  logic [31:0]   hdr_i,
  input  logic [CW-1:0] nwords_i,
  input  logic [31:0]   word_i,
  output logic          start_o,
  output logic [15:0]   target_o,
  output logic [CW-1:0] idx_o
);
  import otpr_pkg::*;

  logic [31:0]   mode_q;
  logic [CW-1:0] idx_q;
  logic [31:0]   rsel;
  logic          data_rd;

  assign start_o  = wr_i && (addr_i == OFF_CTRL) && wdata_i[START_BIT] && !busy_i;
  assign target_o = mode_q[31:16];
  assign idx_o    = idx_q;
  assign data_rd  = rd_i && (addr_i == OFF_DATA);

  always_comb begin
    rsel = '0;
    case (addr_i)
      OFF_CTRL: rsel = '0;
      OFF_MODE: rsel = mode_q;
      OFF_IDX:  rsel = 32'(idx_q);
      OFF_STAT: rsel[BUSY_BIT] = busy_i;
      OFF_HDR:  rsel = hdr_i;
      OFF_DATA: rsel = word_i;
      default:  rsel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      idx_q   <= '0;
      rdata_o <= '0;
    end else begin
      if (wr_i && addr_i == OFF_MODE) mode_q <= wdata_i;
      if (start_o)
        idx_q <= '0;
      else if (wr_i && addr_i == OFF_IDX)
        idx_q <= (wdata_i >= PBUF) ? CW'(PBUF) : CW'(wdata_i);
      else if (data_rd && idx_q != CW'(PBUF))
        idx_q <= idx_q + CW'(1);
      if (rd_i) rdata_o <= rsel;
    end
  end

  // R5: index never runs beyond the buffer depth.
  p_idx_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= CW'(PBUF));

  // R5: a data read past the packet returns zero.
  p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && idx_q >= nwords_i) |=> (rdata_o == 32'd0));

  // R7: the control register reads as zero.
  p_ctrl_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i == OFF_CTRL) |=> (rdata_o == 32'd0));

endmodule

// File: rtl/otpr_pkt_reader.sv
module otpr_pkt_reader #(
  parameter int unsigned OTP_WORDS = 2816,
  parameter int unsigned NPKT      = 6,
  parameter int unsigned PBUF      = 8,
  parameter int unsigned LAT       = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam int unsigned AW = $clog2(OTP_WORDS);
  localparam int unsigned CW = $clog2(PBUF + 1);

  logic          start;
  logic [15:0]   target;
  logic [CW-1:0] idx;
  logic          busy;
  logic          done;
  logic [31:0]   hdr;
  logic [CW-1:0] nwords;
  logic [31:0]   word;
  logic          rom_req;
  logic [AW-1:0] rom_addr;
  logic          rom_vld;
  logic [31:0]   rom_data;

  otpr_regs #(.PBUF(PBUF), .CW(CW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (bus_wr),
    .rd_i     (bus_rd),
    .addr_i   (bus_addr),
    .wdata_i  (bus_wdata),
    .rdata_o  (bus_rdata),
    .busy_i   (busy),
    .hdr_i    (hdr),
    .nwords_i (nwords),
    .word_i   (word),
    .start_o  (start),
    .target_o (target),
    .idx_o    (idx)
  );

  otpr_fetch #(.AW(AW), .PBUF(PBUF), .OTP_WORDS(OTP_WORDS), .CW(CW)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .target_i   (target),
    .busy_o     (busy),
    .done_o     (done),
    .hdr_o      (hdr),
    .nwords_o   (nwords),
    .rd_idx_i   (idx),
    .rd_word_o  (word),
    .rom_req_o  (rom_req),
    .rom_addr_o (rom_addr),
    .rom_vld_i  (rom_vld),
    .rom_data_i (rom_data)
  );

  otpr_rom #(.AW(AW), .LAT(LAT), .NPKT(NPKT)) u_rom (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (rom_req),
    .addr_i (rom_addr),
    .vld_o  (rom_vld),
    .data_o (rom_data)
  );

  // R8: completion of a transfer is never followed by a stray finish.
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/otpr_pkt_reader_bench.sv
module otpr_pkt_reader_bench;

  localparam int NPKT = 6;
  localparam int PBUF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  always #2 clk = ~clk;

  otpr_pkt_reader u_otpr_pkt_reader (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_item_t;

  exp_item_t exp_q[$];
  int  n_chk  = 0;
  int  n_fail = 0;
  logic chk_en = 1'b0;
  int  starts [NPKT+1];

  // Bench-side restatement of the image (R12).
  function automatic int b_size(int k);
    return ((3 * k) % 7) + 1;
  endfunction
  function automatic logic [31:0] b_hdr(int k);
    return {8'h5A, 8'(k), 8'(b_size(k)), 8'h3C};
  endfunction
  function automatic logic [31:0] b_pay(int k, int j);
    return {8'(k), 8'(j), ~8'(k), ~8'(j)};
  endfunction

  // Monitor: pops an expectation for each checked read strobe.
  always @(posedge clk) begin
    if (bus_rd && chk_en) begin
      exp_item_t it;
      #1;
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard: read with no expectation, got %h expected none", bus_rdata);
      end else begin
        it = exp_q.pop_front();
        if (bus_rdata !== it.val) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.val);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_item_t it;
    it.val = e; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; chk_en = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; chk_en = 1'b0;
  endtask

  task automatic poll(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; chk_en = 1'b0;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      poll(8'h0C, v);
      if (!v[6]) return;
    end
    n_chk++; n_fail++;
    $display("FAIL %s: busy never cleared, got 1 expected 0", tag);
  endtask

  task automatic fetch(input int addr);
    wr(8'h04, {16'(addr), 16'h0000});
    wr(8'h00, 32'h0000_0040);
    wait_idle("R2");
  endtask

  initial begin
    starts[0] = 0;
    for (int k = 0; k < NPKT; k++) starts[k+1] = starts[k] + b_size(k) + 2;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    rd(8'h0C, 32'h0, "R10 status");
    rd(8'h20, 32'h0, "R10 header");
    rd(8'h04, 32'h0, "R10 mode");
    rd(8'h08, 32'h0, "R10 index");
    rd(8'h30, 32'h0, "R13 unmapped");

    // R9 mode readback, R1 start, R7 self-clear
    wr(8'h04, {16'(starts[2] + 2), 16'h1234});
    rd(8'h04, {16'(starts[2] + 2), 16'h1234}, "R9 mode readback");
    wr(8'h00, 32'h0000_0040);
    rd(8'h0C, 32'h0000_0040, "R1 busy");
    rd(8'h00, 32'h0, "R7 ctrl reads zero");
    wait_idle("R2");
    rd(8'h0C, 32'h0, "R2 busy cleared");
    rd(8'h20, b_hdr(2), "R2 R3 header mid packet");

    // R4 full stream, R5 padding and saturation
    wr(8'h08, 32'h0);
    for (int j = 0; j <= b_size(2); j++) rd(8'h24, b_pay(2, j), "R4 payload stream");
    rd(8'h08, 32'(b_size(2) + 1), "R9 index readback");
    for (int j = 0; j < 3; j++) rd(8'h24, 32'h0, "R5 past end");
    rd(8'h08, 32'(PBUF), "R5 index saturates");

    // R11 start at a chosen index
    wr(8'h08, 32'd3);
    rd(8'h24, b_pay(2, 3), "R11 indexed start");
    rd(8'h24, b_pay(2, 4), "R11 indexed next");

    // R3 R12: first and last word of every packet
    for (int k = 0; k < NPKT; k++) begin
      fetch(starts[k]);
      rd(8'h20, b_hdr(k), "R3 first word");
      wr(8'h08, 32'h0);
      rd(8'h24, b_pay(k, 0), "R12 payload 0");
      fetch(starts[k+1] - 1);
      rd(8'h20, b_hdr(k), "R3 last word");
      wr(8'h08, 32'h0);
      for (int j = 0; j < b_size(k) + 1; j++) rd(8'h24, b_pay(k, j), "R4 R12 stream");
      rd(8'h24, 32'h0, "R5 pad");
    end

    // R6 start while busy ignored
    wr(8'h04, {16'(starts[1]), 16'h0});
    wr(8'h00, 32'h0000_0040);
    wr(8'h04, {16'(starts[4]), 16'h0});
    wr(8'h00, 32'h0000_0040);
    wait_idle("R6");
    rd(8'h20, b_hdr(1), "R6 header unchanged by second start");
    wr(8'h08, 32'h0);
    rd(8'h24, b_pay(1, 0), "R6 payload unchanged");

    // R8 zero header and far address
    fetch(starts[NPKT]);
    rd(8'h20, 32'h0, "R8 zero header");
    wr(8'h08, 32'h0);
    rd(8'h24, 32'h0, "R8 data zero");
    rd(8'h0C, 32'h0, "R8 busy clear");
    fetch(2000);
    rd(8'h20, 32'h0, "R8 far address");

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule